// File: doc/BRIEF.md
# Atomic Read-Modify-Write Operation ALU

This block is the arithmetic core of an atomic memory update path. A sequencer reads the current word from memory, presents it here together with the operation code and up to two source operands, and gets back two results in the same cycle. One is the word to write back. The other is the word to hand to the requester. The datapath is purely combinational and holds no state.

It covers wrapping integer arithmetic, unsigned and signed minimum and maximum, bitwise logic, exchange, and compare-and-swap. It also covers half- and single-precision floating-point minimum, maximum and compare-and-write. A narrow-mode input selects 16-bit operation. In that mode only the low half of each operand is used, the float ops work in half precision, and the results come back zero-extended. Operation codes outside the defined set raise an illegal flag. For those codes the memory word is passed through untouched.

Top module: `atomic_alu`

## Requirements
- R1: Legal codes are 0 add, 1 sub, 2 inc, 3 dec, 4 unsigned min, 5 unsigned max, 6 exchange, 7 compare-exchange, 8 and, 9 or, 10 xor, 11 signed min, 12 signed max, 13 pre-decrement, 16 float max, 17 float min and 18 float compare-write. Codes 14, 15 and 19 to 31 set illegal_o and drive new_o and ret_o to the full unmodified old_i, in either width mode. Legal codes clear illegal_o.
- R2: Add (old+src0), sub (old-src0), inc (old+1) and dec (old-1) wrap modulo 2^32, or modulo 2^16 in narrow mode. Inc and dec ignore both sources.
- R3: Codes 4 and 5 compare old and src0 as unsigned. Codes 11 and 12 compare them as two's complement at the active width.
- R4: Exchange stores src0. And, or and xor combine old with src0 bit by bit.
- R5: Compare-exchange stores src0 when old equals src1 and keeps old otherwise. In narrow mode only the low 16 bits are compared.
- R6: Pre-decrement stores old-1 and returns that new value on ret_o.
- R7: Every legal code other than pre-decrement returns the old value on ret_o.
- R8: In narrow mode (narrow_i=1), bits 31:16 of every input are ignored. For legal codes, bits 31:16 of new_o and ret_o are zero.
- R9: Float ops treat operands as IEEE single precision (1/8/23) when narrow_i=0. When narrow_i=1 they treat the low 16 bits as IEEE half precision (1/5/10).
- R10: Float max and min store the larger or smaller of old and src0. If exactly one of the two is NaN, the other is stored. If both are NaN, old is kept. -0 orders below +0. Infinities are ordinary values.
- R11: Float compare-write stores src1 when src0 equals old under IEEE equality and keeps old otherwise. +0 equals -0, and a NaN never compares equal.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| op_i | input | 5 | Operation code |
| narrow_i | input | 1 | 16-bit mode: low halves, half-precision floats |
| old_i | input | 32 | Current memory word |
| src0_i | input | 32 | First source operand |
| src1_i | input | 32 | Second source (compare or swap operand) |
| new_o | output | 32 | Word to write back to memory |
| ret_o | output | 32 | Word returned to the requester |
| illegal_o | output | 1 | Operation code is not defined |

## Verification
The bench aims at the points where a plausible design goes quietly wrong. It drives a signed and an unsigned minimum on the same 0x80000000 operand, where a shared comparator picks the wrong winner. It checks pre-decrement at zero, where an implementation that returns the old value answers 0 instead of the wrapped result. For the float ops it pairs -0 with +0, NaN with a number, NaN with NaN and infinity with a finite value, so an integer compare or a missing NaN test yields the wrong stored word. Narrow mode is driven with junk in the upper halves, and one bit pattern is checked in both precisions. A unit that ignores the mode either leaks upper bits or orders the operands differently.

// File: rtl/atomic_alu_pkg.sv
package atomic_alu_pkg;

  typedef enum logic [4:0] {
    OP_ADD     = 5'd0,
    OP_SUB     = 5'd1,
    OP_INC     = 5'd2,
    OP_DEC     = 5'd3,
    OP_UMIN    = 5'd4,
    OP_UMAX    = 5'd5,
    OP_XCHG    = 5'd6,
    OP_CMPXCHG = 5'd7,
    OP_AND     = 5'd8,
    OP_OR      = 5'd9,
    OP_XOR     = 5'd10,
    OP_SMIN    = 5'd11,
    OP_SMAX    = 5'd12,
    OP_PREDEC  = 5'd13,
    OP_FMAX    = 5'd16,
    OP_FMIN    = 5'd17,
    OP_FCMPWR  = 5'd18
  } atom_op_e;

  typedef enum logic [1:0] {
    UNIT_INT  = 2'd0,
    UNIT_FP   = 2'd1,
    UNIT_NONE = 2'd2
  } unit_e;

  typedef struct packed {
    unit_e unit;
    logic  ret_new;
    logic  illegal;
  } op_ctrl_t;

endpackage

// File: rtl/atomic_op_decode.sv
module atomic_op_decode
  import atomic_alu_pkg::*;
(
  input  logic [4:0] op_i,
  output op_ctrl_t   ctrl_o
);

  always_comb begin
    ctrl_o = '{unit: UNIT_NONE, ret_new: 1'b0, illegal: 1'b1};
    case (op_i)
      OP_ADD, OP_SUB, OP_INC, OP_DEC, OP_UMIN, OP_UMAX, OP_XCHG,
      OP_CMPXCHG, OP_AND, OP_OR, OP_XOR, OP_SMIN, OP_SMAX:
        ctrl_o = '{unit: UNIT_INT, ret_new: 1'b0, illegal: 1'b0};
      OP_PREDEC:
        ctrl_o = '{unit: UNIT_INT, ret_new: 1'b1, illegal: 1'b0};
      OP_FMAX, OP_FMIN, OP_FCMPWR:
        ctrl_o = '{unit: UNIT_FP, ret_new: 1'b0, illegal: 1'b0};
      default: ;
    endcase
  end

endmodule

// File: rtl/atomic_int_unit.sv
module atomic_int_unit
  import atomic_alu_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NARROW_W = 16
) (
  input  atom_op_e            op_i,
  input  logic                narrow_i,
  input  logic [DATA_W-1:0]   old_i,
  input  logic [DATA_W-1:0]   src0_i,
  input  logic [DATA_W-1:0]   src1_i,
  output logic [DATA_W-1:0]   res_o
);

  localparam int PAD_W = DATA_W - NARROW_W;

  logic [DATA_W-1:0] keep_mask;
  logic [DATA_W-1:0] a_z, b_z, c_z, a_sx, b_sx, raw;
  logic              u_lt, s_lt;

  assign keep_mask = narrow_i ? {{PAD_W{1'b0}}, {NARROW_W{1'b1}}} : '1;
  assign a_z  = old_i  & keep_mask;
  assign b_z  = src0_i & keep_mask;
  assign c_z  = src1_i & keep_mask;
  assign a_sx = narrow_i ? {{PAD_W{old_i[NARROW_W-1]}},  old_i[NARROW_W-1:0]}  : old_i;
  assign b_sx = narrow_i ? {{PAD_W{src0_i[NARROW_W-1]}}, src0_i[NARROW_W-1:0]} : src0_i;

  // src0 below old
  assign u_lt = b_z < a_z;
  assign s_lt = $signed(b_sx) < $signed(a_sx);

  always_comb begin
    raw = a_z;
    case (op_i)
      OP_ADD:     raw = a_z + b_z;
      OP_SUB:     raw = a_z - b_z;
      OP_INC:     raw = a_z + DATA_W'(1);
      OP_DEC,
      OP_PREDEC:  raw = a_z - DATA_W'(1);
      OP_UMIN:    raw = u_lt ? b_z : a_z;
      OP_UMAX:    raw = u_lt ? a_z : b_z;
      OP_SMIN:    raw = s_lt ? b_sx : a_sx;
      OP_SMAX:    raw = s_lt ? a_sx : b_sx;
      OP_XCHG:    raw = b_z;
      OP_CMPXCHG: raw = (a_z == c_z) ? b_z : a_z;
      OP_AND:     raw = a_z & b_z;
      OP_OR:      raw = a_z | b_z;
      OP_XOR:     raw = a_z ^ b_z;
      default:    raw = a_z;
    endcase
  end

  assign res_o = raw & keep_mask;

  always_comb begin
    if (!$isunknown({op_i, narrow_i, old_i, src0_i, src1_i})) begin
      if (op_i == OP_CMPXCHG && a_z != c_z)
        assert_cmpxchg_miss_keeps_R5: assert (res_o == a_z)
          else $error("compare-exchange miss altered the word");
      if (op_i == OP_UMIN)
        assert_umin_bound_R3: assert (res_o <= a_z && res_o <= b_z)
          else $error("unsigned min above an operand");
    end
  end

endmodule

// File: rtl/atomic_fp_unit.sv
module atomic_fp_unit
  import atomic_alu_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  atom_op_e                 op_i,
  input  logic [EXP_W+MAN_W:0]     old_i,
  input  logic [EXP_W+MAN_W:0]     src0_i,
  input  logic [EXP_W+MAN_W:0]     src1_i,
  output logic [EXP_W+MAN_W:0]     res_o
);

  localparam int FW = 1 + EXP_W + MAN_W;

  function automatic logic is_nan(input logic [FW-1:0] x);
    return (&x[FW-2:MAN_W]) && (|x[MAN_W-1:0]);
  endfunction

  // monotonic unsigned key: -0 sorts just below +0
  function automatic logic [FW-1:0] order_key(input logic [FW-1:0] x);
    return x[FW-1] ? ~x : {1'b1, x[FW-2:0]};
  endfunction

  logic            a_nan, b_nan, ieee_eq, b_gt, b_lt;
  logic [FW-1:0]   key_a, key_b;

  assign a_nan   = is_nan(old_i);
  assign b_nan   = is_nan(src0_i);
  assign key_a   = order_key(old_i);
  assign key_b   = order_key(src0_i);
  assign b_gt    = key_b > key_a;
  assign b_lt    = key_b < key_a;
  assign ieee_eq = !a_nan && !b_nan &&
                   ((old_i == src0_i) || (old_i[FW-2:0] == '0 && src0_i[FW-2:0] == '0));

  always_comb begin
    res_o = old_i;
    case (op_i)
      OP_FMAX: begin
        if (b_nan)      res_o = old_i;
        else if (a_nan) res_o = src0_i;
        else            res_o = b_gt ? src0_i : old_i;
      end
      OP_FMIN: begin
        if (b_nan)      res_o = old_i;
        else if (a_nan) res_o = src0_i;
        else            res_o = b_lt ? src0_i : old_i;
      end
      OP_FCMPWR: res_o = ieee_eq ? src1_i : old_i;
      default:   res_o = old_i;
    endcase
  end

  always_comb begin
    if (!$isunknown({op_i, old_i, src0_i, src1_i})) begin
      if (op_i == OP_FMAX || op_i == OP_FMIN)
        assert_minmax_picks_operand_R10: assert (res_o == old_i || res_o == src0_i)
          else $error("float min/max produced a foreign value");
      if (op_i == OP_FCMPWR && (a_nan || b_nan))
        assert_nan_never_equal_R11: assert (res_o == old_i)
          else $error("NaN compared equal");
    end
  end

endmodule

// File: rtl/atomic_alu.sv
module atomic_alu
  import atomic_alu_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NARROW_W = 16,
  parameter int HALF_EXP = 5,
  parameter int HALF_MAN = 10,
  parameter int SGL_EXP  = 8,
  parameter int SGL_MAN  = 23
) (
  input  logic [4:0]        op_i,
  input  logic              narrow_i,
  input  logic [DATA_W-1:0] old_i,
  input  logic [DATA_W-1:0] src0_i,
  input  logic [DATA_W-1:0] src1_i,
  output logic [DATA_W-1:0] new_o,
  output logic [DATA_W-1:0] ret_o,
  output logic              illegal_o
);

  localparam int PAD_W  = DATA_W - NARROW_W;
  localparam int N_PREC = 2;

  atom_op_e          op_e;
  op_ctrl_t          ctrl;
  logic [DATA_W-1:0] int_res, old_view;
  logic [DATA_W-1:0] fp_res [N_PREC];

  assign op_e     = atom_op_e'(op_i);
  assign old_view = narrow_i ? {{PAD_W{1'b0}}, old_i[NARROW_W-1:0]} : old_i;

  atomic_op_decode u_dec (
    .op_i   (op_i),
    .ctrl_o (ctrl)
  );

  atomic_int_unit #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_int (
    .op_i     (op_e),
    .narrow_i (narrow_i),
    .old_i    (old_i),
    .src0_i   (src0_i),
    .src1_i   (src1_i),
    .res_o    (int_res)
  );

  // index 0: half precision, index 1: single precision
  for (genvar g = 0; g < N_PREC; g++) begin : g_fp
    localparam int EW = (g == 0) ? HALF_EXP : SGL_EXP;
    localparam int MW = (g == 0) ? HALF_MAN : SGL_MAN;
    localparam int FW = 1 + EW + MW;
    logic [FW-1:0] r;

    atomic_fp_unit #(.EXP_W(EW), .MAN_W(MW)) u_fp (
      .op_i   (op_e),
      .old_i  (old_i[FW-1:0]),
      .src0_i (src0_i[FW-1:0]),
      .src1_i (src1_i[FW-1:0]),
      .res_o  (r)
    );

    if (FW < DATA_W) begin : g_ext
      assign fp_res[g] = {{(DATA_W-FW){1'b0}}, r};
    end else begin : g_full
      assign fp_res[g] = r;
    end
  end

  always_comb begin
    new_o = old_i;
    ret_o = old_i;
    case (ctrl.unit)
      UNIT_INT: begin
        new_o = int_res;
        ret_o = ctrl.ret_new ? int_res : old_view;
      end
      UNIT_FP: begin
        new_o = narrow_i ? fp_res[0] : fp_res[1];
        ret_o = old_view;
      end
      default: ;
    endcase
  end

  assign illegal_o = ctrl.illegal;

  always_comb begin
    if (!$isunknown({op_i, narrow_i, old_i, src0_i, src1_i})) begin
      if (illegal_o)
        assert_illegal_passthru_R1: assert (new_o == old_i && ret_o == old_i)
          else $error("illegal code modified data");
      if (!illegal_o && op_i != 5'd13)
        assert_returns_old_R7: assert (ret_o == old_view)
          else $error("return is not the old value");
      if (op_i == 5'd13)
        assert_predec_returns_new_R6: assert (ret_o == new_o)
          else $error("pre-decrement return differs from stored value");
      if (narrow_i && !illegal_o)
        assert_narrow_upper_zero_R8: assert (new_o[DATA_W-1:NARROW_W] == '0 &&
                                             ret_o[DATA_W-1:NARROW_W] == '0)
          else $error("narrow mode leaked upper bits");
    end
  end

endmodule

// File: tb/tb_atomic_alu.sv
`timescale 1ns/1ps
module tb_atomic_alu;

  typedef struct {
    string       tag;
    logic [31:0] exp_new;
    logic [31:0] exp_ret;
    logic        exp_ill;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [4:0]  op = '0;
  logic        narrow = 1'b0;
  logic [31:0] old_w = '0, s0 = '0, s1 = '0;
  logic [31:0] new_w, ret_w;
  logic        ill;

  exp_t exp_q[$];
  int   n_checks = 0;
  int   n_fail   = 0;
  logic done     = 1'b0;

  always #5 clk = ~clk;

  atomic_alu dut (
    .op_i      (op),
    .narrow_i  (narrow),
    .old_i     (old_w),
    .src0_i    (s0),
    .src1_i    (s1),
    .new_o     (new_w),
    .ret_o     (ret_w),
    .illegal_o (ill)
  );

  task automatic drive(input string tag, input logic [4:0] o, input logic nm,
                       input logic [31:0] a, input logic [31:0] b, input logic [31:0] c,
                       input logic [31:0] en, input logic [31:0] er, input logic ei);
    exp_t e;
    @(posedge clk);
    op = o; narrow = nm; old_w = a; s0 = b; s1 = c;
    e.tag = tag; e.exp_new = en; e.exp_ret = er; e.exp_ill = ei;
    exp_q.push_back(e);
  endtask

  // monitor: samples mid-cycle, after the driver's edge
  always @(negedge clk) begin
    if (rst_ni && exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      n_checks++;
      if (new_w !== e.exp_new || ret_w !== e.exp_ret || ill !== e.exp_ill) begin
        n_fail++;
        $display("FAIL %s: new=%h ret=%h ill=%b expected new=%h ret=%h ill=%b",
                 e.tag, new_w, ret_w, ill, e.exp_new, e.exp_ret, e.exp_ill);
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    // reset state: zero inputs, add
    drive("reset R1",       5'd0, 0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 0);
    // R2 wrap, inc/dec ignore sources
    drive("add wrap R2",    5'd0, 0, 32'hFFFF_FFFF, 32'h2, 32'h0, 32'h1, 32'hFFFF_FFFF, 0);
    drive("sub wrap R2",    5'd1, 0, 32'h0, 32'h1, 32'h0, 32'hFFFF_FFFF, 32'h0, 0);
    drive("inc R2",         5'd2, 0, 32'h7, 32'h5, 32'h9, 32'h8, 32'h7, 0);
    drive("dec wrap R2",    5'd3, 0, 32'h0, 32'h3, 32'h4, 32'hFFFF_FFFF, 32'h0, 0);
    // R3 signedness
    drive("umin R3",        5'd4, 0, 32'h8000_0000, 32'h1, 32'h0, 32'h1, 32'h8000_0000, 0);
    drive("umax R3",        5'd5, 0, 32'h8000_0000, 32'h1, 32'h0, 32'h8000_0000, 32'h8000_0000, 0);
    drive("smin R3",        5'd11, 0, 32'h8000_0000, 32'h1, 32'h0, 32'h8000_0000, 32'h8000_0000, 0);
    drive("smax R3",        5'd12, 0, 32'h8000_0000, 32'h1, 32'h0, 32'h1, 32'h8000_0000, 0);
    // R4 exchange and logic
    drive("xchg R4",        5'd6, 0, 32'h1234, 32'hABCD, 32'h0, 32'hABCD, 32'h1234, 0);
    drive("and R4",         5'd8, 0, 32'hF0F0, 32'h3C3C, 32'h0, 32'h3030, 32'hF0F0, 0);
    drive("or R4",          5'd9, 0, 32'hF0F0, 32'h3C3C, 32'h0, 32'hFCFC, 32'hF0F0, 0);
    drive("xor R4",         5'd10, 0, 32'hF0F0, 32'h3C3C, 32'h0, 32'hCCCC, 32'hF0F0, 0);
    // R5 compare-exchange
    drive("cmpxchg hit R5", 5'd7, 0, 32'h5, 32'h9, 32'h5, 32'h9, 32'h5, 0);
    drive("cmpxchg miss R5",5'd7, 0, 32'h5, 32'h9, 32'h6, 32'h5, 32'h5, 0);
    // R6 pre-decrement returns new
    drive("predec R6",      5'd13, 0, 32'h10, 32'h0, 32'h0, 32'hF, 32'hF, 0);
    drive("predec zero R6", 5'd13, 0, 32'h0, 32'h0, 32'h0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0);
    // R1 illegal codes
    drive("illegal 14 R1",  5'd14, 0, 32'hDEAD_BEEF, 32'h1, 32'h2, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 1);
    drive("illegal 15 R1",  5'd15, 1, 32'hDEAD_BEEF, 32'h1, 32'h2, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 1);
    drive("illegal 19 R1",  5'd19, 0, 32'hCAFE_0001, 32'h1, 32'h2, 32'hCAFE_0001, 32'hCAFE_0001, 1);
    drive("illegal 31 R1",  5'd31, 1, 32'h0123_4567, 32'h1, 32'h2, 32'h0123_4567, 32'h0123_4567, 1);
    // R8 narrow integer mode
    drive("narrow add R8",  5'd0, 1, 32'h0001_FFFF, 32'hFFFF_0002, 32'h0, 32'h1, 32'hFFFF, 0);
    drive("narrow smin R8", 5'd11, 1, 32'h0000_8000, 32'h0000_0001, 32'h0, 32'h8000, 32'h8000, 0);
    drive("narrow umin R8", 5'd4, 1, 32'h0000_8000, 32'h0000_0001, 32'h0, 32'h1, 32'h8000, 0);
    drive("narrow predec R6", 5'd13, 1, 32'h0005_0000, 32'h0, 32'h0, 32'hFFFF, 32'hFFFF, 0);
    drive("narrow cmpxchg R5", 5'd7, 1, 32'hAAAA_1234, 32'h0000_5678, 32'hFFFF_1234, 32'h5678, 32'h1234, 0);
    // R9/R10 single precision
    drive("fmax R10",       5'd16, 0, 32'h3F80_0000, 32'h4000_0000, 32'h0, 32'h4000_0000, 32'h3F80_0000, 0);
    drive("fmin R10",       5'd17, 0, 32'h3F80_0000, 32'h4000_0000, 32'h0, 32'h3F80_0000, 32'h3F80_0000, 0);
    drive("fmin neg R10",   5'd17, 0, 32'hBF80_0000, 32'h3F80_0000, 32'h0, 32'hBF80_0000, 32'hBF80_0000, 0);
    drive("fmax nan src R10", 5'd16, 0, 32'h3F80_0000, 32'h7FC0_0000, 32'h0, 32'h3F80_0000, 32'h3F80_0000, 0);
    drive("fmin nan old R10", 5'd17, 0, 32'h7FC0_0000, 32'h4000_0000, 32'h0, 32'h4000_0000, 32'h7FC0_0000, 0);
    drive("fmax two nan R10", 5'd16, 0, 32'h7FC0_0001, 32'h7FC0_0000, 32'h0, 32'h7FC0_0001, 32'h7FC0_0001, 0);
    drive("fmin zeros R10", 5'd17, 0, 32'h0000_0000, 32'h8000_0000, 32'h0, 32'h8000_0000, 32'h0, 0);
    drive("fmax zeros R10", 5'd16, 0, 32'h8000_0000, 32'h0000_0000, 32'h0, 32'h0, 32'h8000_0000, 0);
    drive("fmax inf R10",   5'd16, 0, 32'h7F80_0000, 32'h3F80_0000, 32'h0, 32'h7F80_0000, 32'h7F80_0000, 0);
    // R11 compare-write
    drive("fcmpwr hit R11", 5'd18, 0, 32'h3F80_0000, 32'h3F80_0000, 32'h1234_5678, 32'h1234_5678, 32'h3F80_0000, 0);
    drive("fcmpwr zero R11",5'd18, 0, 32'h0000_0000, 32'h8000_0000, 32'h1, 32'h1, 32'h0, 0);
    drive("fcmpwr nan R11", 5'd18, 0, 32'h7FC0_0000, 32'h7FC0_0000, 32'h1, 32'h7FC0_0000, 32'h7FC0_0000, 0);
    drive("fcmpwr miss R11",5'd18, 0, 32'h3F80_0000, 32'h4000_0000, 32'h1, 32'h3F80_0000, 32'h3F80_0000, 0);
    // R9 half precision
    drive("hfmax R9",       5'd16, 1, 32'h0000_3C00, 32'h0000_C000, 32'h0, 32'h3C00, 32'h3C00, 0);
    drive("hfmin R9",       5'd17, 1, 32'h0000_3C00, 32'h0000_C000, 32'h0, 32'hC000, 32'h3C00, 0);
    drive("hfmax junk R8",  5'd16, 1, 32'hFFFF_3C00, 32'h1234_4000, 32'h0, 32'h4000, 32'h3C00, 0);
    drive("hfmax nan R9",   5'd16, 1, 32'h0000_7E00, 32'h0000_3C00, 32'h0, 32'h3C00, 32'h7E00, 0);
    drive("sfmax same bits R9", 5'd16, 0, 32'h0000_7E00, 32'h0000_3C00, 32'h0, 32'h7E00, 32'h7E00, 0);
    drive("hfcmpwr zero R11", 5'd18, 1, 32'h0000_8000, 32'h0000_0000, 32'h0000_1111, 32'h1111, 32'h8000, 0);
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule